// File: doc/BRIEF.md
# Configuration Port Site-Switch Sequencer

This controller moves access to an internal configuration port from one of two sites to the other. The two sites share a single configuration engine, and only one of them can be live at a time. When a caller asks for the site that is not current, the controller drives the port's select, write-enable and write-data lines with a fixed stream of register packets. The stream synchronizes the outgoing site if needed. It then sets the site-select bit under a mask, issues the desynchronize command and synchronizes the incoming site. When the stream has gone out, the controller reports completion and records the new site.

The write-data bus is either 8 or 32 bits wide. On the narrow bus, each 32-bit word goes out as four bytes, most significant byte first, and the bit order inside each byte is mirrored. On the wide bus, each word goes out unchanged in a single beat. The port has a read-data bus, but this sequencer does not use it, so it has no read-data port.

Top module: `cfg_site_switch`

## Requirements
- R1: After reset, the select and write lines are low, the write bus is zero, busy and done are low, and the current site is top (`site_bottom` = 0). The port is not yet synchronized.
- R2: A switch from a port that is not synchronized emits twelve words in this order: 0xAA995566, 0x20000000, mask header, mask data, control header, control data, command header, 0x0000000D, 0x20000000, 0x20000000, 0xAA995566, 0x20000000.
- R3: Once any switch has completed, the port counts as synchronized. A later switch skips the leading sync and no-op words and emits the remaining ten words.
- R4: The mask data word is 0x40000000. The control data word carries bit 30 = 1 to select the bottom site and bit 30 = 0 to select the top site, with all other bits zero.
- R5: A register-write header is 0x30000001 OR (address << 13). The addresses are 6 for the mask, 5 for control and 4 for command, which gives 0x3000C001, 0x3000A001 and 0x30008001.
- R6: A request that names the site already current emits no beat. It raises done for one cycle, one clock after the request, and busy stays low.
- R7: With an 8-bit bus, each word is sent as bytes [31:24], [23:16], [15:8], [7:0]. Bus bit i carries byte bit 7-i. Select stays high with write high for the whole stream.
- R8: With a 32-bit bus, each word appears unchanged for one cycle, and the words are back to back.
- R9: Busy rises one clock after an accepted request. Done pulses for exactly one cycle after the last beat, and `site_bottom` changes only in that cycle.
- R10: A request that arrives while busy is ignored and does not change the stream or the final site.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Single-cycle switch request |
| sw_bottom | input | 1 | Target site for the request: 1 for bottom, 0 for top |
| cfg_sel | output | 1 | Port select, high while a beat is driven |
| cfg_wr | output | 1 | Port write control, high for a write |
| cfg_wdata | output | BUS_W | Port write-data bus |
| sw_busy | output | 1 | A switch stream is in progress |
| sw_done | output | 1 | One-cycle completion pulse |
| site_bottom | output | 1 | Current site: 1 for bottom, 0 for top |

## Verification
The bench builds two copies side by side, one with BUS_W = 8 and one with BUS_W = 32, and feeds both the same requests. The 8-bit copy covers the byte ordering, the per-byte mirroring and select held high across four-beat words. The 32-bit copy covers single-beat words and the done timing for a stream of a different length. Together they cover the first switch from an unsynchronized port, the shortened stream after that, same-site requests and requests made while busy.

// File: rtl/cfg_site_pkg.sv
package cfg_site_pkg;

  localparam int unsigned IDX_W     = 4;
  localparam int unsigned SEQ_LEN   = 12;
  localparam int unsigned SKIP_SYNC = 2;

  localparam logic [31:0] SYNC_WORD  = 32'hAA99_5566;
  localparam logic [31:0] NOOP_WORD  = 32'h2000_0000;
  localparam logic [31:0] DESYNC_CMD = 32'h0000_000D;
  localparam logic [31:0] MASK_SITE  = 32'h4000_0000;

  localparam logic [13:0] REG_CMD  = 14'd4;
  localparam logic [13:0] REG_CTL  = 14'd5;
  localparam logic [13:0] REG_MASK = 14'd6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  function automatic logic [31:0] wr_header(input logic [13:0] addr);
    wr_header = 32'h3000_0001 | ({18'd0, addr} << 13);
  endfunction

  function automatic logic [31:0] seq_word(input logic [IDX_W-1:0] idx,
                                           input logic            bottom);
    case (idx)
      4'd0:    seq_word = SYNC_WORD;
      4'd1:    seq_word = NOOP_WORD;
      4'd2:    seq_word = wr_header(REG_MASK);
      4'd3:    seq_word = MASK_SITE;
      4'd4:    seq_word = wr_header(REG_CTL);
      4'd5:    seq_word = {1'b0, bottom, 30'd0};
      4'd6:    seq_word = wr_header(REG_CMD);
      4'd7:    seq_word = DESYNC_CMD;
      4'd10:   seq_word = SYNC_WORD;
      default: seq_word = NOOP_WORD;
    endcase
  endfunction

endpackage

// File: rtl/cfg_site_ctrl.sv
module cfg_site_ctrl
  import cfg_site_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        tgt_i,
  input  logic        ser_ready_i,
  input  logic        ser_active_i,
  output logic        load_o,
  output logic [31:0] word_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        site_o
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SEQ_LEN - 1);
  localparam logic [IDX_W-1:0] START_SYN = IDX_W'(SKIP_SYNC);

  seq_state_e       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             tgt_q, tgt_n;
  logic             site_q, site_n;
  logic             synced_q, synced_n;
  logic             done_q, done_n;

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    tgt_n    = tgt_q;
    site_n   = site_q;
    synced_n = synced_q;
    done_n   = 1'b0;
    load_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (tgt_i == site_q) begin
            done_n = 1'b1;
          end else begin
            state_n = ST_RUN;
            tgt_n   = tgt_i;
            idx_n   = synced_q ? START_SYN : '0;
          end
        end
      end
      ST_RUN: begin
        load_o = 1'b1;
        if (ser_ready_i) begin
          if (idx_q == LAST_IDX) state_n = ST_DRAIN;
          else                   idx_n   = idx_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!ser_active_i) begin
          state_n  = ST_IDLE;
          done_n   = 1'b1;
          site_n   = tgt_q;
          synced_n = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      tgt_q    <= 1'b0;
      site_q   <= 1'b0;
      synced_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      idx_q    <= idx_n;
      tgt_q    <= tgt_n;
      site_q   <= site_n;
      synced_q <= synced_n;
      done_q   <= done_n;
    end
  end

  assign word_o = seq_word(idx_q, tgt_q);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign site_o = site_q;

  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R9
  AST_SITE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(site_q) |-> done_q); // R9
  AST_IDX_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) idx_q <= LAST_IDX); // R2
  AST_BUSY_IGNORE:  assert property (@(posedge clk) disable iff (!rst_n) (busy_o && req_i) |=> $stable(tgt_q)); // R10

endmodule

// File: rtl/cfg_word_ser.sv
module cfg_word_ser #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [31:0]      word_i,
  output logic             ready_o,
  output logic             active_o,
  output logic [BUS_W-1:0] data_o
);

  localparam int unsigned BEATS  = 32 / BUS_W;
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              active_q, active_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic [31:0]       word_q, word_n;
  logic              last_beat;
  logic [BUS_W-1:0]  beat_data;

  assign last_beat = (beat_q == LAST_BEAT);
  assign ready_o   = !active_q || last_beat;

  always_comb begin
    active_n = active_q;
    beat_n   = beat_q;
    word_n   = word_q;
    if (load_i && ready_o) begin
      active_n = 1'b1;
      beat_n   = '0;
      word_n   = word_i;
    end else if (active_q && last_beat) begin
      active_n = 1'b0;
    end else if (active_q) begin
      beat_n = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      word_q   <= '0;
    end else begin
      active_q <= active_n;
      beat_q   <= beat_n;
      word_q   <= word_n;
    end
  end

  generate
    if (BUS_W == 32) begin : g_wide
      assign beat_data = word_q;
    end else begin : g_narrow
      logic [7:0] cur_byte;
      assign cur_byte = word_q[(LAST_BEAT - beat_q) * 8 +: 8];
      for (genvar b = 0; b < 8; b++) begin : g_mirror
        assign beat_data[b] = cur_byte[7 - b];
      end
    end
  endgenerate

  assign active_o = active_q;
  assign data_o   = active_q ? beat_data : '0;

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) beat_q <= LAST_BEAT); // R7
  AST_HOLD_WORD:  assert property (@(posedge clk) disable iff (!rst_n) (active_q && !last_beat) |=> $stable(word_q)); // R7

endmodule

// File: rtl/cfg_site_switch.sv
module cfg_site_switch #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic             sw_bottom,
  output logic             cfg_sel,
  output logic             cfg_wr,
  output logic [BUS_W-1:0] cfg_wdata,
  output logic             sw_busy,
  output logic             sw_done,
  output logic             site_bottom
);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        load;
  logic [31:0] word;
  logic        ser_ready;
  logic        ser_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_site_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_i        (sw_req),
    .tgt_i        (sw_bottom),
    .ser_ready_i  (ser_ready),
    .ser_active_i (ser_active),
    .load_o       (load),
    .word_o       (word),
    .busy_o       (sw_busy),
    .done_o       (sw_done),
    .site_o       (site_bottom)
  );

  cfg_word_ser #(.BUS_W(BUS_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (load),
    .word_i   (word),
    .ready_o  (ser_ready),
    .active_o (ser_active),
    .data_o   (cfg_wdata)
  );

  assign cfg_sel = ser_active;
  assign cfg_wr  = ser_active;

  AST_SEL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n) cfg_sel |-> sw_busy); // R7
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_int_n) !sw_busy |-> (cfg_wdata == '0)); // R1

endmodule

// File: tb/tb_cfg_site_switch.sv
module tb_cfg_site_switch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 1'b0;
  logic sw_bottom = 1'b0;

  logic        sel8, wr8, busy8, done8, site8;
  logic [7:0]  data8;
  logic        sel32, wr32, busy32, done32, site32;
  logic [31:0] data32;

  int tests = 0;
  int fails = 0;
  int beats8 = 0;
  int beats32 = 0;
  bit synced_m = 1'b0;
  bit site_m = 1'b0;

  logic [7:0]  q8[$];
  logic [31:0] q32[$];

  always #2 clk = ~clk;

  cfg_site_switch #(.BUS_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_bottom(sw_bottom),
    .cfg_sel(sel8), .cfg_wr(wr8), .cfg_wdata(data8),
    .sw_busy(busy8), .sw_done(done8), .site_bottom(site8)
  );

  cfg_site_switch #(.BUS_W(32)) dut_w (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_bottom(sw_bottom),
    .cfg_sel(sel32), .cfg_wr(wr32), .cfg_wdata(data32),
    .sw_busy(busy32), .sw_done(done32), .site_bottom(site32)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic push_word(input logic [31:0] w);
    for (int k = 3; k >= 0; k--) q8.push_back(mirror(w[k*8 +: 8]));
    q32.push_back(w);
  endtask

  task automatic push_stream(input bit bottom, input bit synced);
    if (!synced) begin
      push_word(32'hAA995566);               // R2
      push_word(32'h20000000);
    end
    push_word(32'h3000C001);                 // R5 mask header
    push_word(32'h40000000);                 // R4 mask data
    push_word(32'h3000A001);                 // R5 control header
    push_word(bottom ? 32'h40000000 : 32'h0); // R4 control data
    push_word(32'h30008001);                 // R5 command header
    push_word(32'h0000000D);
    push_word(32'h20000000);
    push_word(32'h20000000);
    push_word(32'hAA995566);
    push_word(32'h20000000);
  endtask

  // Scoreboard monitors
  always @(negedge clk) begin
    if (rst_n && sel8) begin
      beats8++;
      check(wr8 === 1'b1, "R7 write held", {31'd0, wr8}, 32'd1);
      if (q8.size() == 0) check(1'b0, "R7 unexpected byte", {24'd0, data8}, 32'd0);
      else begin
        logic [7:0] e8;
        e8 = q8.pop_front();
        check(data8 === e8, "R7 byte", {24'd0, data8}, {24'd0, e8});
      end
    end
    if (rst_n && sel32) begin
      beats32++;
      check(wr32 === 1'b1, "R8 write held", {31'd0, wr32}, 32'd1);
      if (q32.size() == 0) check(1'b0, "R8 unexpected word", data32, 32'd0);
      else begin
        logic [31:0] e32;
        e32 = q32.pop_front();
        check(data32 === e32, "R8 word", data32, e32);
      end
    end
  end

  task automatic pulse_req(input bit bottom);
    @(negedge clk);
    sw_bottom = bottom;
    sw_req = 1'b1;
    @(posedge clk);
    #1;
    sw_req = 1'b0;
  endtask

  task automatic same_site(input bit bottom);
    int b8, b32;
    b8 = beats8; b32 = beats32;
    pulse_req(bottom);
    check(done8 === 1'b1 && done32 === 1'b1, "R6 immediate done", {done8, done32}, 2'b11);
    check(busy8 === 1'b0 && busy32 === 1'b0, "R6 no busy", {busy8, busy32}, 2'b00);
    repeat (3) @(posedge clk);
    #1;
    check(done8 === 1'b0 && done32 === 1'b0, "R6 single pulse", {done8, done32}, 2'b00);
    check(beats8 == b8 && beats32 == b32, "R6 no beats", beats8 - b8 + beats32 - b32, 0);
  endtask

  task automatic switch_to(input bit bottom, input bit interfere);
    bit s8, s32;
    s8 = 0; s32 = 0;
    push_stream(bottom, synced_m);
    pulse_req(bottom);
    check(busy8 === 1'b1 && busy32 === 1'b1, "R9 busy after request", {busy8, busy32}, 2'b11);
    if (interfere) pulse_req(~bottom); // R10 request while busy
    for (int i = 0; i < 400 && !(s8 && s32); i++) begin
      @(posedge clk);
      #1;
      if (done8 && !s8) begin
        s8 = 1;
        check(site8 === bottom, "R9 site at done (8)", {31'd0, site8}, {31'd0, bottom});
        check(q8.size() == 0, "R7 all bytes before done", q8.size(), 0);
      end
      if (done32 && !s32) begin
        s32 = 1;
        check(site32 === bottom, "R9 site at done (32)", {31'd0, site32}, {31'd0, bottom});
        check(q32.size() == 0, "R8 all words before done", q32.size(), 0);
      end
      if (!s8) check(site8 === site_m, "R9 site stable while busy", {31'd0, site8}, {31'd0, site_m});
    end
    check(s8 && s32, "R9 done seen", {s8, s32}, 2'b11);
    @(posedge clk);
    #1;
    check(done8 === 1'b0 && done32 === 1'b0, "R9 done one cycle", {done8, done32}, 2'b00);
    check(busy8 === 1'b0 && busy32 === 1'b0, "R10 idle after stream", {busy8, busy32}, 2'b00);
    check(site8 === bottom && site32 === bottom, "R10 final site", {site8, site32}, {bottom, bottom});
    site_m = bottom;
    synced_m = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(sel8 === 1'b0 && sel32 === 1'b0 && wr8 === 1'b0 && wr32 === 1'b0, "R1 select low", {sel8, sel32}, 0);
    check(data8 === 8'd0 && data32 === 32'd0, "R1 bus zero", data32 | data8, 0);
    check(busy8 === 1'b0 && done8 === 1'b0 && busy32 === 1'b0 && done32 === 1'b0, "R1 idle", {busy8, done8}, 0);
    check(site8 === 1'b0 && site32 === 1'b0, "R1 top site", {site8, site32}, 0);

    same_site(1'b0);          // R6 top while top
    switch_to(1'b1, 1'b0);    // R2 R4 R5 R7 R8 first stream
    check(beats32 == 12 && beats8 == 48, "R2 full stream length", beats32, 12);
    same_site(1'b1);          // R6 bottom while bottom
    switch_to(1'b0, 1'b0);    // R3 shortened stream back to top
    check(beats32 == 22 && beats8 == 88, "R3 shortened stream length", beats32, 22);
    switch_to(1'b1, 1'b1);    // R10 request ignored while busy
    check(beats32 == 32, "R10 stream unchanged", beats32, 32);

    repeat (5) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule